// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words. It is parameterized in depth and has a write port and a read port, each on its own clock. The two clocks may be unrelated, or the same net may drive both. The write side keeps the Full and Almost-Full flags and the read side keeps the Empty and Almost-Empty flags. All four flags are active low. Each side learns the other side's position through a Gray-coded pointer that is resynchronized into its own clock domain. Because of this, the flags are always conservative: a flag may report less room or less data than the buffer holds, never more.

While reset is held, a dual-purpose write input is captured. If it is high, the block runs in two-enable mode and the pin acts as a second, active-high write enable, which is useful for depth expansion. If it is low, the block runs in programmable-flag mode and a single active-low write enable governs writes. The Almost-Empty and Almost-Full thresholds are set by parameters and default to 7. Reads move the head word into a registered output. An active-low output enable drives that register onto the data bus, or releases the bus to high impedance.

DEPTH must be a power of two.

Top module: `flagfifo9_top`

## Requirements
- R1: Words leave the buffer in the order they were written, with all 9 bits intact.
- R2: The level of `wr_en2_ld` on the write clock while reset is active selects the mode: 1 selects two-enable mode and 0 selects programmable-flag mode. The mode does not change until the next reset.
- R3: In two-enable mode a write occurs on a rising `wr_clk` edge only when `wr_en1_n`=0 and `wr_en2_ld`=1. In programmable-flag mode `wr_en1_n`=0 alone writes, whatever the level of `wr_en2_ld`.
- R4: A rising `rd_clk` edge loads the output register only when `rd_en1_n`=0 and `rd_en2_n`=0. With either read enable at 1, the output register keeps its value and no word is consumed.
- R5: `full_n` is 0 when DEPTH words are stored. Write attempts while `full_n`=0 are ignored, so the stored contents stay unchanged.
- R6: `empty_n` is 0 when no word is stored. Read attempts while `empty_n`=0 are ignored, so the output register keeps its value.
- R7: Once the buffer is idle, `almost_empty_n` is 0 when the occupancy is at or below EMPTY_OFS, and `almost_full_n` is 0 when the free space is at or below FULL_OFS. Both thresholds default to 7.
- R8: While `rst_n`=0: `full_n`=1, `almost_full_n`=1, `empty_n`=0 and `almost_empty_n`=0, the output register is 0, and both pointers return to the first location.
- R9: With `oe_n`=1 the `rd_data` bus is high impedance. With `oe_n`=0 it drives the output register.
- R10: A write side and a read side that run at the same time, each obeying its own flag, lose no word and reorder no word. Each pointer moves by exactly one Gray-code bit per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 9 | Word to store |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or mode strap sampled during reset |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Output register contents, or high impedance |
| empty_n | output | 1 | Empty flag, read clock domain, active low |
| almost_empty_n | output | 1 | Almost-Empty flag, read clock domain, active low |
| almost_full_n | output | 1 | Almost-Full flag, write clock domain, active low |
| full_n | output | 1 | Full flag, write clock domain, active low |

## Verification
Storing a word and consuming a word can fall in the same pair of clock edges. In that case each side acts on a stale copy of the other side's pointer. The test provokes this overlap by prefilling eight words, then running a writer and a reader concurrently on clocks offset by 7 ns. The writer is faster and repeatedly runs into Full, while the reader drains behind it. Correctness is judged by comparing every word the reader receives against the arithmetic sequence the writer produced. A depth sweep from zero to full then confirms the settled flag levels, and confirms that writes are dropped at Full and reads are dropped at Empty.

// File: rtl/flagfifo9_pkg.sv
package flagfifo9_pkg;
  localparam int DATA_W = 9;
  typedef logic [DATA_W-1:0] word_t;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/flagfifo9_rst_sync.sv
module flagfifo9_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/flagfifo9_sync.sv
module flagfifo9_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/flagfifo9_wr_ctl.sv
module flagfifo9_wr_ctl
  import flagfifo9_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int FULL_OFS = 7,
  parameter int AW       = 6,
  parameter int PW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [PW-1:0] rgray_sync,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          wr_fire,
  output logic          full_n,
  output logic          afull_n
);
  localparam logic [PW-1:0] CAP      = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LEVEL = PW'(DEPTH - FULL_OFS);

  logic          two_we_q;
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_sync, used_d;
  logic          full_n_q, full_n_d, afull_n_q, afull_n_d, push_req;

  // mode strap: captured on every write clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) two_we_q <= wen2_ld;
  end

  always_comb begin
    push_req  = two_we_q ? (!wen1_n && wen2_ld) : !wen1_n;
    wr_fire   = push_req && full_n_q;
    wbin_d    = wbin_q + PW'(wr_fire);
    wgray_d   = wbin_d ^ (wbin_d >> 1);
    rbin_sync = PW'(gray_to_bin(32'(rgray_sync)));
    used_d    = wbin_d - rbin_sync;
    full_n_d  = (used_d != CAP);
    afull_n_d = (used_d < AF_LEVEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wbin_q    <= wbin_d;
      wgray_q   <= wgray_d;
      full_n_q  <= full_n_d;
      afull_n_q <= afull_n_d;
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign full_n  = full_n_q;
  assign afull_n = afull_n_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n_q && push_req) |=> $stable(wbin_q));
  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wbin_q - rbin_sync) <= CAP));
  // R10
  wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(two_we_q));
endmodule

// File: rtl/flagfifo9_rd_ctl.sv
module flagfifo9_rd_ctl
  import flagfifo9_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int EMPTY_OFS = 7,
  parameter int AW        = 6,
  parameter int PW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [PW-1:0] wgray_sync,
  input  word_t         mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output word_t         q,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam logic [PW-1:0] CAP      = PW'(DEPTH);
  localparam logic [PW-1:0] AE_LEVEL = PW'(EMPTY_OFS);

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_sync, used_d;
  logic          empty_n_q, empty_n_d, aempty_n_q, aempty_n_d, pop_req, rd_fire;
  word_t         q_q, q_d;

  always_comb begin
    pop_req    = !ren1_n && !ren2_n;
    rd_fire    = pop_req && empty_n_q;
    rbin_d     = rbin_q + PW'(rd_fire);
    rgray_d    = rbin_d ^ (rbin_d >> 1);
    wbin_sync  = PW'(gray_to_bin(32'(wgray_sync)));
    used_d     = wbin_sync - rbin_d;
    empty_n_d  = (rgray_d != wgray_sync);
    aempty_n_d = (used_d > AE_LEVEL);
    q_d        = rd_fire ? mem_rdata : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
      q_q        <= '0;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= rgray_d;
      empty_n_q  <= empty_n_d;
      aempty_n_q <= aempty_n_d;
      q_q        <= q_d;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign q        = q_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n_q && pop_req) |=> ($stable(rbin_q) && $stable(q_q)));
  // R4
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ren1_n && !ren2_n) |=> $stable(q_q));
  // R6
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wbin_sync - rbin_q) <= CAP));
  // R10
  rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/flagfifo9_top.sv
module flagfifo9_top
  import flagfifo9_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int EMPTY_OFS   = 7,
  parameter int FULL_OFS    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic        wr_clk,
  input  logic        rd_clk,
  input  logic        rst_n,
  input  logic [8:0]  wr_data,
  input  logic        wr_en1_n,
  input  logic        wr_en2_ld,
  input  logic        rd_en1_n,
  input  logic        rd_en2_n,
  input  logic        oe_n,
  output logic [8:0]  rd_data,
  output logic        empty_n,
  output logic        almost_empty_n,
  output logic        almost_full_n,
  output logic        full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          w_rst_n, r_rst_n, wr_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  word_t         mem [DEPTH];
  word_t         q_reg;

  flagfifo9_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(w_rst_n));
  flagfifo9_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(r_rst_n));

  flagfifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(w_rst_n), .din(rgray), .dout(rgray_ws));
  flagfifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(r_rst_n), .din(wgray), .dout(wgray_rs));

  flagfifo9_wr_ctl #(.DEPTH(DEPTH), .FULL_OFS(FULL_OFS), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(w_rst_n), .wen1_n(wr_en1_n), .wen2_ld(wr_en2_ld),
    .rgray_sync(rgray_ws), .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire),
    .full_n(full_n), .afull_n(almost_full_n));

  flagfifo9_rd_ctl #(.DEPTH(DEPTH), .EMPTY_OFS(EMPTY_OFS), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(r_rst_n), .ren1_n(rd_en1_n), .ren2_n(rd_en2_n),
    .wgray_sync(wgray_rs), .mem_rdata(mem[raddr]), .raddr(raddr), .rgray(rgray),
    .q(q_reg), .empty_n(empty_n), .aempty_n(almost_empty_n));

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  assign rd_data = oe_n ? 9'bz : q_reg;

  // R8
  rst_out_chk: assert property (@(posedge rd_clk)
    !r_rst_n |-> (q_reg == '0 && !empty_n && !almost_empty_n));
endmodule

// File: tb/flagfifo9_top_test.sv
`timescale 1ns/1ps
module flagfifo9_top_test;
  localparam int DEPTH = 16;

  logic       wr_clk, rd_clk, rst_n;
  logic [8:0] wr_data;
  logic       wr_en1_n, wr_en2_ld, rd_en1_n, rd_en2_n, oe_n;
  logic [8:0] rd_data;
  logic       empty_n, almost_empty_n, almost_full_n, full_n;

  int checks = 0;
  int errors = 0;

  flagfifo9_top #(.DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_data(rd_data), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n), .full_n(full_n));

  initial begin wr_clk = 0; forever #10 wr_clk = ~wr_clk; end
  initial begin rd_clk = 0; #7; forever #10 rd_clk = ~rd_clk; end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 0; wr_en2_ld = strap; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic put_raw(input logic [8:0] d);
    wr_data = d; wr_en1_n = 0;
    @(negedge wr_clk);
    wr_en1_n = 1;
  endtask

  task automatic put_wait(input logic [8:0] d);
    while (!full_n) @(negedge wr_clk);
    put_raw(d);
  endtask

  task automatic get(output logic [8:0] d, output bit ok);
    @(negedge rd_clk);
    if (!empty_n) begin ok = 0; d = rd_data; end
    else begin
      rd_en1_n = 0; rd_en2_n = 0;
      @(negedge rd_clk);
      rd_en1_n = 1; rd_en2_n = 1;
      d = rd_data; ok = 1;
    end
  endtask

  function automatic logic [8:0] pat(input int n, input int i);
    return 9'((n * 37 + i * 11 + 5) & 511);
  endfunction

  function automatic logic [8:0] cpat(input int k);
    return 9'((k * 23 + 3) & 511);
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] d;
    bit ok;
    oe_n = 0; wr_data = 0;
    do_reset(1'b0);

    // R8: values while reset is held after activity
    put_raw(9'h1A5); settle(); get(d, ok);
    rst_n = 0; #3;
    chk(rd_data == 0, "R8", "output register", rd_data, 0);
    chk(empty_n == 0 && almost_empty_n == 0, "R8", "empty flags", {empty_n, almost_empty_n}, 0);
    chk(full_n == 1 && almost_full_n == 1, "R8", "full flags", {full_n, almost_full_n}, 3);
    do_reset(1'b0);

    // R1 R5 R6 R7: sweep every fill level
    for (int n = 0; n <= DEPTH; n++) begin
      logic [8:0] last;
      do_reset(1'b0);
      for (int i = 0; i < n; i++) put_raw(pat(n, i));
      if (n == DEPTH) for (int i = 0; i < 3; i++) put_raw(9'h1FF - 9'(i));
      settle();
      chk(empty_n == (n > 0), "R6", $sformatf("empty_n at %0d", n), empty_n, n > 0);
      chk(full_n == (n < DEPTH), "R5", $sformatf("full_n at %0d", n), full_n, n < DEPTH);
      chk(almost_empty_n == (n > 7), "R7", $sformatf("almost_empty_n at %0d", n), almost_empty_n, n > 7);
      chk(almost_full_n == (DEPTH - n > 7), "R7", $sformatf("almost_full_n at %0d", n), almost_full_n, DEPTH - n > 7);
      last = 0;
      for (int i = 0; i < n; i++) begin
        get(d, ok);
        chk(ok && d == pat(n, i), "R1", $sformatf("word %0d of %0d", i, n), d, pat(n, i));
        last = pat(n, i);
      end
      get(d, ok);
      chk(!ok, "R6", "read after drain blocked", ok, 0);
      chk(rd_data == last, "R6", "output held at empty", rd_data, last);
    end

    // R2 R3: two-enable mode
    do_reset(1'b1);
    wr_en2_ld = 0; put_raw(9'h0F0); settle();
    chk(empty_n == 0, "R3", "write with second enable low ignored", empty_n, 0);
    wr_en2_ld = 1; put_raw(9'h155); settle();
    get(d, ok);
    chk(ok && d == 9'h155, "R2", "two-enable write accepted", d, 9'h155);
    // R3: flag mode, second pin low does not block
    do_reset(1'b0);
    wr_en2_ld = 0; put_raw(9'h0AA); settle();
    get(d, ok);
    chk(ok && d == 9'h0AA, "R3", "single-enable write", d, 9'h0AA);

    // R4: one read enable alone does nothing
    do_reset(1'b0);
    put_raw(9'h011); put_raw(9'h122); settle();
    get(d, ok);
    @(negedge rd_clk); rd_en1_n = 0; rd_en2_n = 1;
    @(negedge rd_clk); rd_en1_n = 1; rd_en2_n = 0;
    @(negedge rd_clk); rd_en2_n = 1;
    chk(rd_data == 9'h011, "R4", "output held with one enable", rd_data, 9'h011);
    get(d, ok);
    chk(ok && d == 9'h122, "R4", "next word not skipped", d, 9'h122);

    // R9: output enable
    oe_n = 1; #1;
    chk(rd_data === 9'bz, "R9", "bus released", 0, 0);
    oe_n = 0; #1;
    chk(rd_data == 9'h122, "R9", "bus driven", rd_data, 9'h122);

    // R10: concurrent writer and reader
    do_reset(1'b0);
    for (int k = 0; k < 8; k++) put_raw(cpat(k));
    fork
      begin
        for (int k = 8; k < 48; k++) put_wait(cpat(k));
      end
      begin
        int got, guard;
        got = 0; guard = 0;
        while (got < 48 && guard < 2000) begin
          get(d, ok);
          if (ok) begin
            chk(d == cpat(got), "R10", $sformatf("concurrent word %0d", got), d, cpat(got));
            got++;
          end
          guard++;
        end
        chk(got == 48, "R10", "concurrent word count", got, 48);
      end
    join
    settle();
    chk(empty_n == 0, "R10", "empty after concurrent run", empty_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule